// File: doc/BRIEF.md
# Block-Storage Disk Controller DMA Engine

This block emulates a simple disk controller whose disk image lives in on-chip RAM. Software programs it through a small word-wide register port: a starting block number, a host bus address, a word count given as a negative number, and a function code. Setting the go bit starts the transfer. The engine then moves 16-bit words between host memory, through a DMA master port, and the RAM image. The image holds whole 256-word blocks and has no seek or rotational delay.

A transfer may be shorter than a block or may run across several consecutive blocks. A write to disk that ends partway through a block fills the rest of that block with zeros. A read from disk that ends early simply stops. The host bus address is 22 bits wide: the upper six bits live in an extension register, and its two lowest bits also appear in the control/status word. When a transfer completes, the engine sets ready. If interrupts are enabled, it also requests an interrupt.

Top module: `dsk_dma_engine`

## Requirements
- R1: After reset the control/status word reads 0x0080 (ready set, everything else clear), the word count, bus address, block number and extension registers read 0, and the interrupt output is low.
- R2: Register select values: 0 is control/status, 1 is word count, 2 is bus address (low 16 bits), 3 is block number, and 4 is the extension register (bits 5:0). Any other select value reads 0. Control/status fields:
  - bit 0 is go and always reads 0;
  - bits 2:1 are the function, where 1 writes disk from memory and 2 reads disk into memory;
  - bits 5:4 are the extension mirror;
  - bit 6 is interrupt enable;
  - bit 7 is ready and is read-only.
- R3: Extension bits 1:0 and control/status bits 5:4 are the same storage. A write through either location is visible in both.
- R4: Each DMA word uses the 22-bit address {extension, bus address}. After each word this address advances by 2, and a carry out of bit 15 increments the extension register.
- R5: The word count holds the negative of the number of words and increments once per word. The transfer ends when it reaches zero, and it reads 0 afterwards.
- R6: Function 1 copies successive host words into the disk image, starting at word 0 of the block named by the block number.
- R7: A disk write whose count ends inside a block writes zeros to the remaining words of that block.
- R8: Function 2 copies successive disk words to host memory. A read that ends inside a block performs no host writes past the count and leaves the block number unchanged.
- R9: The block number increments each time the last word (word 255) of a block has been moved or zero-filled.
- R10: The interrupt output is high exactly when a command has completed since the last go and interrupt enable is set. Setting go clears ready and the interrupt at the next clock edge.
- R11: While ready is clear, register writes have no effect.
- R12: A DMA request holds its address, direction and write data unchanged until the cycle in which it is acknowledged.
- R13: Go with function 0 or 3, or with a word count of 0, issues no DMA request and returns ready (raising the interrupt if enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| dma_req | output | 1 | DMA cycle request, held until acknowledged |
| dma_we | output | 1 | 1 = write to host memory, 0 = read from host memory |
| dma_addr | output | 22 | Host byte address |
| dma_wdata | output | 16 | Data for host memory writes |
| dma_rdata | input | 16 | Data returned by host memory reads |
| dma_ack | input | 1 | Completes the current DMA cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the carry from the 16-bit bus address into the extension register in the middle of a transfer. The stimulus reaches it by programming a bus address of 0xFFFE with a two-word read. The scoreboard expects the second host write at 0x10000, and afterwards both the extension register and the control/status mirror must read 1.

Zero-fill is checked the only way the ports allow: the block is read back after a short write, and the bench also reads the block number. A write that is ignored while busy is exposed the same way, by issuing it mid-transfer and then reading back the block number and the data path.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
    localparam int WORD_W    = 16;
    localparam int BLK_WORDS = 256;
    localparam int OFF_W     = $clog2(BLK_WORDS);
    localparam int EXT_W     = 6;
    localparam int ADDR_W    = WORD_W + EXT_W;
    localparam int SEL_W     = 3;

    localparam logic [SEL_W-1:0] SEL_CSR = 3'd0;
    localparam logic [SEL_W-1:0] SEL_WC  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BA  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DA  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_XBA = 3'd4;

    localparam logic [1:0] FN_WR = 2'd1;  // memory -> disk
    localparam logic [1:0] FN_RD = 2'd2;  // disk -> memory

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RDRAM, S_RDBUS, S_ZERO, S_FIN
    } eng_st_e;

    typedef struct packed {
        eng_st_e             st;
        logic [1:0]          func;
        logic                ie;
        logic                ready;
        logic                done;
        logic [WORD_W-1:0]   wc;
        logic [ADDR_W-1:0]   ba;
        logic [WORD_W-1:0]   da;
        logic [OFF_W-1:0]    woff;
    } eng_t;
endpackage

// File: rtl/dsk_store.sv
module dsk_store #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dsk_rdmux.sv
module dsk_rdmux
    import dsk_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        func,
    input  logic              ie,
    input  logic              ready,
    input  logic [WORD_W-1:0] wc,
    input  logic [ADDR_W-1:0] ba,
    input  logic [WORD_W-1:0] da,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CSR: rdata = {8'h00, ready, ie, ba[WORD_W+1:WORD_W], 1'b0, func, 1'b0};
            SEL_WC:  rdata = wc;
            SEL_BA:  rdata = ba[WORD_W-1:0];
            SEL_DA:  rdata = da;
            SEL_XBA: rdata = {{(WORD_W-EXT_W){1'b0}}, ba[ADDR_W-1:WORD_W]};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/dsk_dma_engine.sv
module dsk_dma_engine
    import dsk_pkg::*;
#(
    parameter int BLK_IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              dma_req,
    output logic              dma_we,
    output logic [21:0]       dma_addr,
    output logic [15:0]       dma_wdata,
    input  logic [15:0]       dma_rdata,
    input  logic              dma_ack,
    output logic              irq_o
);
    localparam int RAM_AW = BLK_IDX_W + OFF_W;

    localparam eng_t ENG_RST = '{st: S_IDLE, func: 2'd0, ie: 1'b0, ready: 1'b1,
                                 done: 1'b0, wc: '0, ba: '0, da: '0, woff: '0};

    eng_t q, d;

    logic              ram_we;
    logic              ram_re;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] ram_q;
    logic [RAM_AW-1:0] cur_loc;
    logic              ready_w;

    assign cur_loc = {q.da[BLK_IDX_W-1:0], q.woff};
    assign ready_w = q.ready;

    // Advance every per-word counter and pick the following state.
    function automatic eng_t step_word(input eng_t s);
        eng_t r;
        r      = s;
        r.ba   = s.ba + ADDR_W'(2);
        r.wc   = s.wc + 1'b1;
        r.woff = s.woff + 1'b1;
        if (s.woff == '1) r.da = s.da + 1'b1;
        if (s.wc == '1)
            r.st = (s.func == FN_WR && s.woff != '1) ? S_ZERO : S_FIN;
        else
            r.st = (s.func == FN_WR) ? S_FETCH : S_RDRAM;
        return r;
    endfunction

    always_comb begin
        d         = q;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_wdata = dma_rdata;
        case (q.st)
            S_IDLE: begin
                if (reg_wr) begin
                    case (reg_sel)
                        SEL_WC:  d.wc = reg_wdata;
                        SEL_BA:  d.ba[WORD_W-1:0] = reg_wdata;
                        SEL_DA:  d.da = reg_wdata;
                        SEL_XBA: d.ba[ADDR_W-1:WORD_W] = reg_wdata[EXT_W-1:0];
                        SEL_CSR: begin
                            d.func = reg_wdata[2:1];
                            d.ie   = reg_wdata[6];
                            d.ba[WORD_W+1:WORD_W] = reg_wdata[5:4];
                            if (reg_wdata[0]) begin
                                d.ready = 1'b0;
                                d.done  = 1'b0;
                                d.woff  = '0;
                                if (q.wc == '0)
                                    d.st = S_FIN;
                                else if (reg_wdata[2:1] == FN_WR)
                                    d.st = S_FETCH;
                                else if (reg_wdata[2:1] == FN_RD)
                                    d.st = S_RDRAM;
                                else
                                    d.st = S_FIN;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_FETCH: begin
                if (dma_ack) begin
                    ram_we = 1'b1;
                    d      = step_word(q);
                end
            end
            S_RDRAM: begin
                ram_re = 1'b1;
                d.st   = S_RDBUS;
            end
            S_RDBUS: begin
                if (dma_ack) d = step_word(q);
            end
            S_ZERO: begin
                ram_we    = 1'b1;
                ram_wdata = '0;
                d.woff    = q.woff + 1'b1;
                if (q.woff == '1) begin
                    d.da = q.da + 1'b1;
                    d.st = S_FIN;
                end
            end
            S_FIN: begin
                d.ready = 1'b1;
                d.done  = 1'b1;
                d.st    = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    dsk_store #(.AW(RAM_AW), .DW(WORD_W)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (cur_loc),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (cur_loc),
        .rdata (ram_q)
    );

    dsk_rdmux u_rdmux (
        .sel   (reg_sel),
        .func  (q.func),
        .ie    (q.ie),
        .ready (q.ready),
        .wc    (q.wc),
        .ba    (q.ba),
        .da    (q.da),
        .rdata (reg_rdata)
    );

    assign dma_req   = (q.st == S_FETCH) || (q.st == S_RDBUS);
    assign dma_we    = (q.st == S_RDBUS);
    assign dma_addr  = q.ba;
    assign dma_wdata = ram_q;
    assign irq_o     = q.done & q.ie;
endmodule

// File: rtl/dsk_dma_chk.sv
module dsk_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_sel,
    input logic        go_bit,
    input logic        dma_req,
    input logic        dma_we,
    input logic [21:0] dma_addr,
    input logic [15:0] dma_wdata,
    input logic        dma_ack,
    input logic        irq_o,
    input logic        ready
);
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> (dma_req && $stable(dma_addr) && $stable(dma_we)));

    p_wdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_we && !dma_ack) |=> $stable(dma_wdata));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !dma_req);

    p_irq_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ready);

    p_go_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd0 && go_bit && ready) |=> (!ready && !irq_o));
endmodule

bind dsk_dma_engine dsk_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .go_bit    (reg_wdata[0]),
    .dma_req   (dma_req),
    .dma_we    (dma_we),
    .dma_addr  (dma_addr),
    .dma_wdata (dma_wdata),
    .dma_ack   (dma_ack),
    .irq_o     (irq_o),
    .ready     (ready_w)
);

// File: tb/tb_dsk_dma_engine.sv
module tb_dsk_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        dma_req, dma_we;
    logic [21:0] dma_addr;
    logic [15:0] dma_wdata;
    logic [15:0] dma_rdata = 16'h0;
    logic        dma_ack = 1'b0;
    logic        irq_o;

    always #10 clk = ~clk;

    dsk_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_rdata(dma_rdata), .dma_ack(dma_ack), .irq_o(irq_o)
    );

    typedef struct { int a; logic [15:0] d; } exp_t;
    exp_t        expq[$];
    logic [15:0] hmem [int];
    int          nchk = 0;
    int          nerr = 0;
    int          dma_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Host memory model and scoreboard monitor, acting away from the rising edge.
    always @(negedge clk) begin
        if (dma_ack) dma_ack = 1'b0;
        else if (dma_req) begin
            dma_cnt++;
            dma_ack = 1'b1;
            if (dma_we) begin
                hmem[int'(dma_addr)] = dma_wdata;
                if (expq.size() == 0)
                    chk(1'b0, "R8 unexpected host write", 32'(dma_addr), 32'hFFFFFFFF);
                else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(e.a == int'(dma_addr) && e.d == dma_wdata, "R12 host write addr/data",
                        {dma_addr[15:0], dma_wdata}, {e.a[15:0], e.d});
                end
            end else begin
                dma_rdata = hmem.exists(int'(dma_addr)) ? hmem[int'(dma_addr)] : 16'h0;
            end
        end
    end

    task automatic wreg(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] s, output logic [15:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_ready();
        logic [15:0] v;
        v = 16'h0;
        for (int i = 0; i < 5000; i++) begin
            rreg(3'd0, v);
            if (v[7]) break;
        end
        chk(v[7], "R5 transfer completes", 32'(v), 32'h80);
    endtask

    function automatic logic [15:0] pat(input logic [15:0] seed, input int i);
        return seed + 16'(i * 37);
    endfunction

    task automatic fill(input int base, input int n, input logic [15:0] seed);
        for (int i = 0; i < n; i++) hmem[base + 2*i] = pat(seed, i);
    endtask

    task automatic setup(input logic [15:0] da, input logic [15:0] ba, input int n);
        wreg(3'd3, da);
        wreg(3'd2, ba);
        wreg(3'd1, 16'(-n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(3'd0, v); chk(v == 16'h0080, "R1 csr after reset", 32'(v), 32'h80);
        rreg(3'd1, v); chk(v == 16'h0, "R1 wc after reset", 32'(v), 0);
        rreg(3'd4, v); chk(v == 16'h0, "R1 xba after reset", 32'(v), 0);
        chk(irq_o == 1'b0, "R1 irq after reset", 32'(irq_o), 0);
        rreg(3'd6, v); chk(v == 16'h0, "R2 unused select reads 0", 32'(v), 0);

        // R3 mirror both ways
        wreg(3'd4, 16'h002B);
        rreg(3'd0, v); chk(v[5:4] == 2'b11, "R3 xba low bits in csr", 32'(v), 32'hB0);
        wreg(3'd0, 16'h0010);
        rreg(3'd4, v); chk(v == 16'h0029, "R3 csr bits into xba", 32'(v), 32'h29);
        rreg(3'd0, v); chk(v == 16'h0090, "R2 csr layout", 32'(v), 32'h90);
        wreg(3'd4, 16'h0000);

        // R6 full block write, block 2
        fill(32'h1000, 256, 16'hA000);
        setup(16'd2, 16'h1000, 256);
        wreg(3'd0, 16'h0043);
        wait_ready();
        chk(irq_o == 1'b1, "R10 irq with enable", 32'(irq_o), 1);
        rreg(3'd1, v); chk(v == 16'h0, "R5 wc ends at zero", 32'(v), 0);
        rreg(3'd3, v); chk(v == 16'd3, "R9 block advance after full block", 32'(v), 3);
        rreg(3'd2, v); chk(v == 16'h1200, "R4 bus address stepped by 2", 32'(v), 32'h1200);

        // R8 read back full block, interrupts off
        setup(16'd2, 16'h4000, 256);
        for (int i = 0; i < 256; i++) expq.push_back('{32'h4000 + 2*i, pat(16'hA000, i)});
        wreg(3'd0, 16'h0005);
        chk(irq_o == 1'b0, "R10 go clears irq", 32'(irq_o), 0);
        wait_ready();
        chk(expq.size() == 0, "R6 all block words returned", expq.size(), 0);
        chk(irq_o == 1'b0, "R10 no irq when disabled", 32'(irq_o), 0);

        // R7 partial write zero-fills block 2
        fill(32'h2000, 10, 16'h5100);
        setup(16'd2, 16'h2000, 10);
        wreg(3'd0, 16'h0003);
        wait_ready();
        rreg(3'd3, v); chk(v == 16'd3, "R9 block advance after zero-fill", 32'(v), 3);
        setup(16'd2, 16'h5000, 256);
        for (int i = 0; i < 256; i++)
            expq.push_back('{32'h5000 + 2*i, (i < 10) ? pat(16'h5100, i) : 16'h0});
        wreg(3'd0, 16'h0005);
        wait_ready();
        chk(expq.size() == 0, "R7 zero-filled block read back", expq.size(), 0);

        // R8 partial read stops early
        hmem[32'h600A] = 16'hDEAD;
        setup(16'd2, 16'h6000, 5);
        for (int i = 0; i < 5; i++) expq.push_back('{32'h6000 + 2*i, pat(16'h5100, i)});
        wreg(3'd0, 16'h0005);
        wait_ready();
        chk(expq.size() == 0, "R8 partial read words", expq.size(), 0);
        chk(hmem[32'h600A] == 16'hDEAD, "R8 no write past count", 32'(hmem[32'h600A]), 32'hDEAD);
        rreg(3'd3, v); chk(v == 16'd2, "R8 block unchanged after partial read", 32'(v), 2);

        // R9 multi-block write of 300 words into blocks 4 and 5
        fill(32'h3000, 300, 16'h7700);
        setup(16'd4, 16'h3000, 300);
        wreg(3'd0, 16'h0003);
        wait_ready();
        rreg(3'd3, v); chk(v == 16'd6, "R9 two block advances", 32'(v), 6);
        setup(16'd4, 16'h8000, 512);
        for (int i = 0; i < 512; i++)
            expq.push_back('{32'h8000 + 2*i, (i < 300) ? pat(16'h7700, i) : 16'h0});
        wreg(3'd0, 16'h0005);
        wait_ready();
        chk(expq.size() == 0, "R9 multi-block readback", expq.size(), 0);

        // R4 carry from bus address into extension
        setup(16'd2, 16'hFFFE, 2);
        expq.push_back('{32'h0FFFE, pat(16'h5100, 0)});
        expq.push_back('{32'h10000, pat(16'h5100, 1)});
        wreg(3'd0, 16'h0005);
        wait_ready();
        chk(expq.size() == 0, "R4 carry addresses", expq.size(), 0);
        rreg(3'd4, v); chk(v == 16'h0001, "R4 extension incremented", 32'(v), 1);
        rreg(3'd0, v); chk(v[5:4] == 2'b01, "R3 mirror follows carry", 32'(v[5:4]), 1);
        rreg(3'd2, v); chk(v == 16'h0002, "R4 low address wrapped", 32'(v), 2);
        wreg(3'd4, 16'h0000);

        // R11 writes while busy are ignored
        setup(16'd4, 16'hA000, 256);
        for (int i = 0; i < 256; i++) expq.push_back('{32'hA000 + 2*i, pat(16'h7700, i)});
        wreg(3'd0, 16'h0005);
        wreg(3'd3, 16'd7);
        wreg(3'd1, 16'h0000);
        wreg(3'd4, 16'h0015);
        wait_ready();
        chk(expq.size() == 0, "R11 transfer unaffected by busy writes", expq.size(), 0);
        rreg(3'd3, v); chk(v == 16'd5, "R11 block write ignored", 32'(v), 5);
        rreg(3'd4, v); chk(v == 16'h0, "R11 extension write ignored", 32'(v), 0);

        // R13 no-op commands
        c0 = dma_cnt;
        wreg(3'd1, 16'hFFFC);
        wreg(3'd0, 16'h0041);
        wait_ready();
        chk(dma_cnt == c0, "R13 function 0 issues no DMA", dma_cnt, c0);
        chk(irq_o == 1'b1, "R13 no-op raises irq", 32'(irq_o), 1);
        wreg(3'd0, 16'h0047);
        chk(irq_o == 1'b0, "R10 go clears pending irq", 32'(irq_o), 0);
        wait_ready();
        chk(dma_cnt == c0, "R13 function 3 issues no DMA", dma_cnt, c0);
        wreg(3'd1, 16'h0000);
        wreg(3'd0, 16'h0005);
        wait_ready();
        chk(dma_cnt == c0, "R13 zero count issues no DMA", dma_cnt, c0);
        wreg(3'd0, 16'h0000);
        chk(irq_o == 1'b0, "R10 irq drops when enable cleared", 32'(irq_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule